// File: doc/BRIEF.md
# Register-Mapped Serial Port with Single-Character Handshake

This block is a compact asynchronous serial port placed behind a plain 32-bit register bus. The bus has an address, a read strobe and a write strobe. Three word registers are decoded. The data word carries the character and two handshake flags. The control word holds the interface mode, two ready-override enables and a sticky overrun flag. The clock word holds a 12-bit scale and a 16-bit step, which are passed to an external bit-rate generator.

Characters travel as 8N1 frames: one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line idles high. Timing comes from an oversampling tick `baud_tick` that an outside generator pulses `OVS` times per bit. Each direction holds exactly one character:
- Software launches a transmit by writing the character with the send flag set.
- Software acknowledges a received character by writing 1 to the receive flag.

Top module: `serlink_regif`

## Requirements
- R1: After reset the data word reads 0x200: send flag (bit 9) = 1, receive flag (bit 8) = 0, character = 0. The control word reads 0, the clock word reads its reset value (0 by default), and `txd` is high.
- R2: A write is decoded only at byte offsets 0x00 (data), 0x04 (control) and 0x08 (clock). The clock word keeps step in bits 15:0 and scale in bits 27:16, which drive `cfg_step` and `cfg_scale`. Its other bits read 0. A read of any other offset returns 0. `bus_rdata` is loaded on the clock edge where `bus_rd` is high.
- R3: A data write with bit 9 set loads bits 7:0 and sends one frame on `txd`: a low start bit, data bits LSB first, then a high stop bit, each `OVS` ticks long. Bit 9 reads 0 from the cycle after the write until the stop bit has ended.
- R4: A data write with bit 9 set while bit 9 reads 0 is ignored. The frame in flight is unchanged and no extra frame follows.
- R5: A loaded character does not start while `peer_ready` is low and control bit 7 (transmit override) is 0. Setting bit 7 releases it.
- R6: A received frame sets data bit 8 and places the character in bits 7:0. A data write with bit 8 set clears bit 8.
- R7: The start bit is checked half a bit after the falling edge. A shorter low pulse is ignored. A frame whose stop bit samples low is discarded, and the receiver then waits for the line to go high before it looks for a new start bit.
- R8: If a frame completes while bit 8 is still 1 and is not being acknowledged in that cycle, the old character is kept and control bit 4 (overrun) is set. Overrun stays 1 until a control write with bit 4 = 1.
- R9: A data write with bits 9 and 8 both 0 has no effect. A data write with both bits set sends the character and acknowledges the received one in the same cycle.
- R10: `rx_ready_out` is high when data bit 8 is 0 or control bit 8 (receive override) is 1.
- R11: Control bits 3:2 hold the interface mode (1 = DTE, 2 = DCE), read back unchanged and drive `if_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is loaded on this edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| baud_tick | input | 1 | Oversampling tick, `OVS` pulses per bit |
| peer_ready | input | 1 | Remote side can accept a character |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_ready_out | output | 1 | This side can accept a character |
| if_mode | output | 2 | Interface mode field |
| cfg_step | output | 16 | Step value for the bit-rate generator |
| cfg_scale | output | 12 | Scale value for the bit-rate generator |

## Verification
The bench targets these corner cases:
- A second send while the transmitter is busy. A design that accepts it corrupts or duplicates a frame.
- A transmit held back by a low `peer_ready` and then released by the override. A wrong design leaks a start bit early or never sends.
- A glitch shorter than half a bit, and a frame with a low stop bit. A careless receiver delivers a phantom character or locks onto the broken stop bit as a new start.
- Two frames with no acknowledgement between them, which must keep the first character and raise the sticky overrun.
- Data writes that carry neither flag or both flags. These expose a decode that acts on the character bits alone or drops one of the two actions.

// File: rtl/serlink_pkg.sv
package serlink_pkg;
   localparam int OFF_DATA = 'h0;
   localparam int OFF_CTRL = 'h4;
   localparam int OFF_CLK  = 'h8;

   localparam int D_RXF = 8;
   localparam int D_TXF = 9;

   localparam int C_OVR   = 4;
   localparam int C_MODE  = 2;
   localparam int C_TXOVR = 7;
   localparam int C_RXOVR = 8;

   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK
   } rx_state_t;
endpackage

// File: rtl/serlink_tx.sv
module serlink_tx #(
   parameter int OVS = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       go,
   input  logic       load,
   input  logic [7:0] din,
   output logic       busy,
   output logic       txd
);
   localparam int CW = $clog2(OVS);

   logic [9:0]    sh;
   logic [3:0]    bitn;
   logic [CW-1:0] tcnt;
   logic          started;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '1;
         bitn    <= '0;
         tcnt    <= '0;
         started <= 1'b0;
         busy    <= 1'b0;
      end else if (load && !busy) begin
         sh      <= {1'b1, din, 1'b0};
         bitn    <= '0;
         tcnt    <= '0;
         started <= 1'b0;
         busy    <= 1'b1;
      end else if (busy && tick) begin
         if (!started) begin
            started <= go;
            tcnt    <= '0;
         end else if (tcnt == CW'(OVS - 1)) begin
            tcnt <= '0;
            sh   <= {1'b1, sh[9:1]};
            if (bitn == 4'd9) begin
               busy    <= 1'b0;
               started <= 1'b0;
            end else begin
               bitn <= bitn + 4'd1;
            end
         end else begin
            tcnt <= tcnt + CW'(1);
         end
      end
   end

   assign txd = started ? sh[0] : 1'b1;

   AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !started && !(tick && go)) |=> !started); // R5
   AST_TX_END_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> txd); // R3
endmodule

// File: rtl/serlink_rx.sv
module serlink_rx
   import serlink_pkg::*;
#(
   parameter int OVS = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxs,
   output logic       done,
   output logic [7:0] dout
);
   localparam int RCW  = $clog2(OVS + 1);
   localparam int HALF = OVS / 2;

   rx_state_t      st;
   logic [RCW-1:0] cnt;
   logic [RCW-1:0] nxt;
   logic [2:0]     bitn;
   logic [7:0]     sh;

   assign nxt  = cnt + RCW'(1);
   assign dout = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= RX_IDLE;
         cnt  <= '0;
         bitn <= '0;
         sh   <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            RX_IDLE: if (tick && !rxs) begin
               st  <= RX_START;
               cnt <= '0;
            end
            RX_START: if (tick) begin
               if (nxt == RCW'(HALF)) begin
                  cnt  <= '0;
                  bitn <= '0;
                  st   <= rxs ? RX_IDLE : RX_DATA;
               end else begin
                  cnt <= nxt;
               end
            end
            RX_DATA: if (tick) begin
               if (nxt == RCW'(OVS)) begin
                  cnt <= '0;
                  sh  <= {rxs, sh[7:1]};
                  if (bitn == 3'd7) st <= RX_STOP;
                  else bitn <= bitn + 3'd1;
               end else begin
                  cnt <= nxt;
               end
            end
            RX_STOP: if (tick) begin
               if (nxt == RCW'(OVS)) begin
                  cnt  <= '0;
                  done <= rxs;
                  st   <= rxs ? RX_IDLE : RX_BREAK;
               end else begin
                  cnt <= nxt;
               end
            end
            RX_BREAK: if (rxs) st <= RX_IDLE;
            default: st <= RX_IDLE;
         endcase
      end
   end

   AST_RX_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(st) == RX_STOP)); // R6
   AST_RX_STOP_SEEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(rxs)); // R7
endmodule

// File: rtl/serlink_regif.sv
module serlink_regif
   import serlink_pkg::*;
#(
   parameter int          ADDR_W      = 4,
   parameter int          OVS         = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [15:0] STEP_RST    = 16'h0000,
   parameter logic [11:0] SCALE_RST   = 12'h000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              baud_tick,
   input  logic              peer_ready,
   input  logic              rxd,
   output logic              txd,
   output logic              rx_ready_out,
   output logic [1:0]        if_mode,
   output logic [15:0]       cfg_step,
   output logic [11:0]       cfg_scale
);
   if (OVS < 4 || OVS > 64) begin : g_bad_ovs
      $error("serlink_regif: OVS must lie in 4..64");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("serlink_regif: SYNC_STAGES must lie in 0..4");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("serlink_regif: ADDR_W must be at least 4");
   end

   logic wr_data, wr_ctrl, wr_clk, tx_load, rx_ack;
   logic tx_busy, rx_done, rx_s;
   logic [7:0] rx_new, rx_byte;
   logic rx_valid, ovr, tx_ovr, rx_ovr;
   logic unused_wbits;

   assign unused_wbits = ^{bus_wdata[31:28], bus_wdata[27:10]};

   assign wr_data = bus_wr && (bus_addr == ADDR_W'(OFF_DATA));
   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
   assign wr_clk  = bus_wr && (bus_addr == ADDR_W'(OFF_CLK));
   assign tx_load = wr_data && bus_wdata[D_TXF];
   assign rx_ack  = wr_data && bus_wdata[D_RXF];

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = rxd;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '1;
         else begin
            q[0] <= rxd;
            for (int k = 1; k < SYNC_STAGES; k++) q[k] <= q[k-1];
         end
      end
      assign rx_s = q[SYNC_STAGES-1];
   end

   serlink_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .go(peer_ready | tx_ovr),
      .load(tx_load), .din(bus_wdata[7:0]), .busy(tx_busy), .txd(txd));

   serlink_rx #(.OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxs(rx_s),
      .done(rx_done), .dout(rx_new));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         if_mode   <= 2'd0;
         tx_ovr    <= 1'b0;
         rx_ovr    <= 1'b0;
         ovr       <= 1'b0;
         cfg_step  <= STEP_RST;
         cfg_scale <= SCALE_RST;
         rx_valid  <= 1'b0;
         rx_byte   <= 8'h00;
      end else begin
         if (wr_ctrl) begin
            if_mode <= bus_wdata[C_MODE +: 2];
            tx_ovr  <= bus_wdata[C_TXOVR];
            rx_ovr  <= bus_wdata[C_RXOVR];
         end
         if (wr_clk) begin
            cfg_step  <= bus_wdata[15:0];
            cfg_scale <= bus_wdata[27:16];
         end
         if (rx_done && (!rx_valid || rx_ack)) begin
            rx_valid <= 1'b1;
            rx_byte  <= rx_new;
         end else if (rx_ack) begin
            rx_valid <= 1'b0;
         end
         if (rx_done && rx_valid && !rx_ack) ovr <= 1'b1;
         else if (wr_ctrl && bus_wdata[C_OVR]) ovr <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else if (bus_rd) begin
         bus_rdata <= '0;
         if (bus_addr == ADDR_W'(OFF_DATA))
            bus_rdata <= {22'd0, !tx_busy, rx_valid, rx_byte};
         else if (bus_addr == ADDR_W'(OFF_CTRL))
            bus_rdata <= {23'd0, rx_ovr, tx_ovr, 2'd0, ovr, if_mode, 2'd0};
         else if (bus_addr == ADDR_W'(OFF_CLK))
            bus_rdata <= {4'd0, cfg_scale, cfg_step};
      end
   end

   assign rx_ready_out = rx_ovr | !rx_valid;

   AST_RX_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ack) |=> $stable(rx_byte)); // R8
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !(wr_ctrl && bus_wdata[C_OVR])) |=> ovr); // R8
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ack && !rx_done) |=> !rx_valid); // R6
   AST_TX_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && !tx_busy) |=> tx_busy); // R3
endmodule

// File: tb/serlink_regif_tb.sv
module serlink_regif_tb;
   localparam int BITCLK = 16;

   logic clk = 0, rst_n = 0;
   logic [3:0] bus_addr = 0;
   logic bus_wr = 0, bus_rd = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic baud_tick = 0, peer_ready = 1, rxd = 1;
   logic txd, rx_ready_out;
   logic [1:0] if_mode;
   logic [15:0] cfg_step;
   logic [11:0] cfg_scale;

   int n_chk = 0, n_err = 0;
   bit done_flag = 0;
   logic [1:0] m_mode = 0;
   logic [15:0] m_step = 0;
   logic [11:0] m_scale = 0;
   logic [7:0] got[$];

   serlink_regif #(.ADDR_W(4), .OVS(8), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .baud_tick(baud_tick), .peer_ready(peer_ready), .rxd(rxd), .txd(txd),
      .rx_ready_out(rx_ready_out), .if_mode(if_mode), .cfg_step(cfg_step),
      .cfg_scale(cfg_scale));

   always #4 clk = ~clk;
   always @(posedge clk) baud_tick <= rst_n ? ~baud_tick : 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-clock reference model compare of configuration outputs (R2, R11)
   always @(negedge clk) if (rst_n && !done_flag) begin
      chk(if_mode == m_mode, "R11 if_mode", 32'(if_mode), 32'(m_mode));
      chk({cfg_scale, cfg_step} == {m_scale, m_step}, "R2 cfg",
          {4'd0, cfg_scale, cfg_step}, {4'd0, m_scale, m_step});
   end

   // line monitor for txd
   initial forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
         logic [7:0] b;
         repeat (BITCLK/2) @(negedge clk);
         chk(txd == 1'b0, "R3 start bit", 32'(txd), 0);
         for (int i = 0; i < 8; i++) begin
            repeat (BITCLK) @(negedge clk);
            b[i] = txd;
         end
         repeat (BITCLK) @(negedge clk);
         chk(txd == 1'b1, "R3 stop bit", 32'(txd), 1);
         got.push_back(b);
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(posedge clk);
      #1;
      if (a == 4'h4) m_mode = d[3:2];
      if (a == 4'h8) begin m_step = d[15:0]; m_scale = d[27:16]; end
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1;
      @(negedge clk);
      bus_rd = 0;
      v = bus_rdata;
   endtask

   task automatic wait_tx_idle();
      logic [31:0] v;
      for (int i = 0; i < 400; i++) begin
         rd(4'h0, v);
         if (v[9]) break;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic send_rx(input logic [7:0] b, input logic stopv);
      @(negedge clk);
      rxd = 0;
      repeat (BITCLK) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         repeat (BITCLK) @(negedge clk);
      end
      rxd = stopv;
      repeat (BITCLK) @(negedge clk);
      rxd = 1;
      repeat (BITCLK) @(negedge clk);
   endtask

   task automatic expect_tx(input logic [7:0] b, input string req);
      chk(got.size() == 1, req, 32'(got.size()), 1);
      if (got.size() > 0) begin
         chk(got[0] == b, req, 32'(got[0]), 32'(b));
         got.delete();
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd(4'h0, v); chk(v == 32'h200, "R1 data reset", v, 32'h200);
      rd(4'h4, v); chk(v == 0, "R1 ctrl reset", v, 0);
      rd(4'h8, v); chk(v == 0, "R1 clk reset", v, 0);
      chk(txd == 1, "R1 txd idle", 32'(txd), 1);
      // R2 decode
      rd(4'hC, v); chk(v == 0, "R2 unmapped read", v, 0);
      wr(4'h8, 32'hFABC_1234);
      rd(4'h8, v); chk(v == 32'h0ABC_1234, "R2 clk word", v, 32'h0ABC_1234);
      wr(4'hC, 32'h0000_02EE);
      rd(4'h0, v); chk(v == 32'h200, "R2 unmapped write", v, 32'h200);
      // R11 mode
      wr(4'h4, 32'h0000_0008);
      rd(4'h4, v); chk(v == 32'h8, "R11 ctrl readback", v, 32'h8);
      // R3 transmit
      wr(4'h0, 32'h2A5);
      rd(4'h0, v); chk(v[9] == 0, "R3 busy after send", 32'(v[9]), 0);
      wait_tx_idle();
      expect_tx(8'hA5, "R3 frame A5");
      wr(4'h0, 32'h23C);
      wait_tx_idle();
      expect_tx(8'h3C, "R3 frame 3C");
      // R4 send while busy
      wr(4'h0, 32'h255);
      wr(4'h0, 32'h2AA);
      wait_tx_idle();
      repeat (2*BITCLK) @(negedge clk);
      expect_tx(8'h55, "R4 busy send ignored");
      // R5 blocked transmit then override
      peer_ready = 0;
      wr(4'h0, 32'h2C3);
      repeat (300) @(negedge clk);
      chk(got.size() == 0 && txd == 1, "R5 held", 32'(got.size()), 0);
      rd(4'h0, v); chk(v[9] == 0, "R5 pending", 32'(v[9]), 0);
      wr(4'h4, 32'h88);
      wait_tx_idle();
      expect_tx(8'hC3, "R5 override release");
      wr(4'h4, 32'h8);
      peer_ready = 1;
      // R6 receive and acknowledge, R10 ready out
      chk(rx_ready_out == 1, "R10 ready when empty", 32'(rx_ready_out), 1);
      send_rx(8'h5A, 1);
      rd(4'h0, v); chk(v == 32'h35A, "R6 received", v, 32'h35A);
      chk(rx_ready_out == 0, "R10 not ready when full", 32'(rx_ready_out), 0);
      wr(4'h0, 32'h100);
      rd(4'h0, v); chk(v[8] == 0, "R6 ack clears", 32'(v[8]), 0);
      // R7 glitch and bad stop
      @(negedge clk); rxd = 0;
      repeat (4) @(negedge clk); rxd = 1;
      repeat (200) @(negedge clk);
      rd(4'h0, v); chk(v[8] == 0, "R7 glitch ignored", 32'(v[8]), 0);
      send_rx(8'h77, 0);
      repeat (50) @(negedge clk);
      rd(4'h0, v); chk(v[8] == 0, "R7 bad stop dropped", 32'(v[8]), 0);
      send_rx(8'h11, 1);
      rd(4'h0, v); chk(v == 32'h311, "R7 recover", v, 32'h311);
      wr(4'h0, 32'h100);
      // R8 overrun
      send_rx(8'h81, 1);
      send_rx(8'h42, 1);
      rd(4'h0, v); chk(v == 32'h381, "R8 old kept", v, 32'h381);
      rd(4'h4, v); chk(v == 32'h18, "R8 overrun set", v, 32'h18);
      wr(4'h4, 32'h18);
      rd(4'h4, v); chk(v == 32'h8, "R8 overrun cleared", v, 32'h8);
      wr(4'h0, 32'h100);
      // R9 no-flag write and both-flag write
      send_rx(8'h99, 1);
      wr(4'h0, 32'h0FF);
      repeat (200) @(negedge clk);
      rd(4'h0, v); chk(v == 32'h399, "R9 no-flag write", v, 32'h399);
      chk(got.size() == 0, "R9 no frame", 32'(got.size()), 0);
      wr(4'h0, 32'h366);
      rd(4'h0, v); chk(v == 32'h099, "R9 both flags", v, 32'h099);
      wait_tx_idle();
      expect_tx(8'h66, "R9 both flags frame");
      // R10 receive override
      wr(4'h4, 32'h108);
      send_rx(8'h10, 1);
      rd(4'h0, v); chk(v[8] == 1, "R10 byte held", 32'(v[8]), 1);
      chk(rx_ready_out == 1, "R10 override", 32'(rx_ready_out), 1);
      wr(4'h0, 32'h100);
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule